// File: doc/BRIEF.md
# Programmable Power-of-Two Interval Timer

This block is a periodic trigger source for a queue-driven conversion sequencer. The interval is always a power of two, counted in periods of the conversion clock. A 4-bit rate code selects that power. The conversion clock reaches the block as a single-cycle enable on the system clock. The timer runs while the scan enable is high. It emits a trigger pulse one system clock wide each time an interval elapses, then reloads and keeps counting with no dead time.

The trigger goes out whether or not the sequencer can use it. The sequencer decides whether a trigger resumes a paused queue or counts as an overrun. At end of queue the sequencer raises the hold-reset input. Hold-reset clears the counter at once and has priority over everything else. A rate code outside the legal range keeps the timer idle. A new code written while the timer runs is taken up at the next reload, so the interval already in progress keeps its length.

All pins are plain control pins. The only output is a pulse, which has no back-pressure, so the block has no valid/ready interface.

Top module: `pow2_interval_timer`

## Requirements
- R1: After reset `trig_o` is low, the timer is idle and the counter holds zero.
- R2: Rate codes 0 to 10 select an interval of 2^(7+code) conversion-clock ticks. The tick count starts with the first tick edge after the start edge. The start edge is the first rising clock edge at which `scan_en`=1, `hold_rst`=0 and the code is legal.
- R3: At each expiry the timer reloads and starts the next interval at once, so triggers repeat exactly one interval apart while the enable stays high.
- R4: The counter advances only at edges where `tick_en`=1. At all other edges it holds its value.
- R5: `trig_o` is registered and lasts exactly one system clock. It is high in the cycle that follows the edge at which the final tick of an interval is counted.
- R6: If `scan_en` is low at an edge, the timer stops and clears. When `scan_en` rises again, a full interval is counted from zero.
- R7: While `hold_rst` is high the counter is cleared, no trigger is produced and the timer cannot start. This holds even when `scan_en` is high.
- R8: Codes 11 to 15 are illegal, and an illegal code never starts the timer. If the code is illegal when a reload happens, the trigger for that expiry is still produced, and the timer then goes idle. It starts again on its own once a legal code is present while it is enabled.
- R9: A rate code change during an interval does not change that interval's length. The new code takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle qualifier marking each conversion-clock tick |
| rate_sel | input | 4 | Rate code; interval = 2^(7+code) ticks for codes 0..10 |
| scan_en | input | 1 | Timer runs while high |
| hold_rst | input | 1 | End-of-queue hold; clears and blocks the timer |
| trig_o | output | 1 | One-cycle trigger pulse at each elapsed interval |

## Verification
The embedded properties assume that every input is synchronous to `clk` and is sampled only at rising edges. They also assume that `tick_en` can come at any rate, so the counter-hold and pulse-width properties do not rely on a fixed tick spacing. The properties place no restriction on when `rate_sel`, `scan_en` or `hold_rst` change. The bench changes all of these inputs only at falling edges. It drives `tick_en` from a free-running divider, so that every rising edge sees settled values.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int RATE_W_DEF  = 4;
  localparam int EXP_MIN_DEF = 7;
  localparam int EXP_MAX_DEF = 17;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/itmr_rate_decode.sv
module itmr_rate_decode
  import itmr_pkg::*;
#(
  parameter int RATE_W  = RATE_W_DEF,
  parameter int EXP_MIN = EXP_MIN_DEF,
  parameter int EXP_MAX = EXP_MAX_DEF,
  localparam int CNT_W  = EXP_MAX
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              legal_o,
  output logic [CNT_W-1:0]  last_o
);
  localparam int MAX_CODE = EXP_MAX - EXP_MIN;

  assign legal_o = (rate_i <= RATE_W'(MAX_CODE));

  // terminal count = 2^(EXP_MIN+code) - 1 : bit i set when i < EXP_MIN+code
  for (genvar i = 0; i < CNT_W; i++) begin : g_last
    if (i < EXP_MIN) begin : g_low
      assign last_o[i] = legal_o;
    end else begin : g_high
      assign last_o[i] = legal_o && (rate_i > RATE_W'(i - EXP_MIN));
    end
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             at_last_o,
  output logic [CNT_W-1:0] cnt_o
);
  assign at_last_o = (cnt_o == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (clear_i) begin
      cnt_o <= '0;
    end else if (adv_i) begin
      cnt_o <= at_last_o ? '0 : cnt_o + 1'b1;
    end
  end

  // R2: count never passes the latched terminal value
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= limit_i);

  // R4: without advance or clear the count holds
  p_cnt_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !adv_i) |=> $stable(cnt_o));
endmodule

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en_i,
  input  logic             hold_i,
  input  logic             tick_i,
  input  logic             legal_i,
  input  logic [CNT_W-1:0] last_i,
  input  logic             at_last_i,
  output logic             cnt_clear_o,
  output logic             cnt_adv_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             running_o,
  output logic             trig_o
);
  tmr_state_e state_q;
  logic       go;
  logic       expire;

  assign go          = scan_en_i && !hold_i;
  assign running_o   = (state_q == TMR_RUN);
  assign cnt_clear_o = !running_o || !go;
  assign cnt_adv_o   = running_o && go && tick_i;
  assign expire      = cnt_adv_o && at_last_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMR_IDLE;
      limit_o <= '0;
      trig_o  <= 1'b0;
    end else begin
      trig_o <= expire;
      if (!go) begin
        state_q <= TMR_IDLE;
      end else if (!running_o) begin
        if (legal_i) begin
          state_q <= TMR_RUN;
          limit_o <= last_i;
        end
      end else if (expire) begin
        limit_o <= last_i;
        state_q <= legal_i ? TMR_RUN : TMR_IDLE;
      end
    end
  end

  // R5: trigger is a single-cycle pulse
  p_trig_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R4: a trigger needs a counted tick on the previous edge
  p_trig_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(tick_i));

  // R7: hold-reset suppresses the trigger and idles the timer
  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!trig_o && !running_o));

  // R8: an illegal code never starts an idle timer
  p_no_bad_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !legal_i) |=> !running_o);

  // R9: latched limit only moves at start or reload
  p_limit_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && go && !expire) |=> $stable(limit_o));

  // R6: dropping the enable stops the timer
  p_enable_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en_i |=> !running_o);
endmodule

// File: rtl/pow2_interval_timer.sv
module pow2_interval_timer
  import itmr_pkg::*;
#(
  parameter int RATE_W  = RATE_W_DEF,
  parameter int EXP_MIN = EXP_MIN_DEF,
  parameter int EXP_MAX = EXP_MAX_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              scan_en,
  input  logic              hold_rst,
  output logic              trig_o
);
  localparam int CNT_W = EXP_MAX;

  logic             legal;
  logic [CNT_W-1:0] last_dec;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cnt;
  logic             at_last;
  logic             cnt_clear;
  logic             cnt_adv;
  logic             running;

  itmr_rate_decode #(
    .RATE_W (RATE_W),
    .EXP_MIN(EXP_MIN),
    .EXP_MAX(EXP_MAX)
  ) u_dec (
    .rate_i (rate_sel),
    .legal_o(legal),
    .last_o (last_dec)
  );

  itmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en_i  (scan_en),
    .hold_i     (hold_rst),
    .tick_i     (tick_en),
    .legal_i    (legal),
    .last_i     (last_dec),
    .at_last_i  (at_last),
    .cnt_clear_o(cnt_clear),
    .cnt_adv_o  (cnt_adv),
    .limit_o    (limit_q),
    .running_o  (running),
    .trig_o     (trig_o)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (cnt_clear),
    .adv_i    (cnt_adv),
    .limit_i  (limit_q),
    .at_last_o(at_last),
    .cnt_o    (cnt)
  );

  // R2: a legal code decodes to a power of two minus one
  p_limit_pow2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> $onehot({1'b0, last_dec} + 1'b1));

  // R1/R6: an idle timer keeps its counter at zero
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (cnt == '0));
endmodule

// File: tb/pow2_interval_timer_tb_top.sv
module pow2_interval_timer_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       scan_en = 1'b0;
  logic       hold_rst = 1'b0;
  logic       trig_o;

  int    n_tests = 0;
  int    n_fail = 0;
  int    cycles = 0;
  int    tick_div = 1;
  int    tick_ph = 0;
  string cur_req = "R1";

  // reference model state
  bit m_active = 1'b0;
  int m_ticks = 0;
  int m_period = 0;
  bit m_trig = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pow2_interval_timer dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .rate_sel(rate_sel),
    .scan_en (scan_en),
    .hold_rst(hold_rst),
    .trig_o  (trig_o)
  );

  // tick generator, driven on falling edges
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % tick_div;
    tick_en = (tick_ph == 0);
  end

  // behavioural reference: integer tick counting against 2^(7+code)
  always @(posedge clk) begin
    automatic bit go = scan_en && !hold_rst;
    automatic bit ok = (rate_sel <= 4'd10);
    if (!rst_n) begin
      m_active = 0; m_ticks = 0; m_trig = 0;
    end else begin
      m_trig = 0;
      if (!go) begin
        m_active = 0; m_ticks = 0;
      end else if (!m_active) begin
        if (ok) begin
          m_active = 1; m_ticks = 0; m_period = 1 << (7 + int'(rate_sel));
        end
      end else if (tick_en) begin
        m_ticks++;
        if (m_ticks == m_period) begin
          m_trig = 1; m_ticks = 0;
          if (ok) m_period = 1 << (7 + int'(rate_sel));
          else m_active = 0;
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      n_tests++;
      if (trig_o !== m_trig) begin
        n_fail++;
        $display("FAIL %s per-cycle trig actual=%0b expected=%0b at cycle %0d",
                 cur_req, trig_o, m_trig, cycles);
      end
    end
    if (cycles == WDOG_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WDOG_LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // wait for a trigger; returns falling edges waited, -1 if none within limit
  task automatic wait_trig(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (trig_o === 1'b1) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic stop_cycle();
    scan_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", "trig after reset", int'(trig_o), 0);

    // R2 / R3 / R5: rate 0 -> 128 ticks
    cur_req = "R2";
    rate_sel = 4'd0; scan_en = 1'b1;
    wait_trig(2000, n);
    check("R2", "start to first trigger, code 0", n, 129);
    @(negedge clk);
    check("R5", "trigger width", int'(trig_o), 0);
    cur_req = "R3";
    wait_trig(2000, n);
    check("R3", "gap code 0", n + 1, 128);

    // R9: change code mid-interval
    cur_req = "R9";
    rate_sel = 4'd2;
    wait_trig(2000, n);
    check("R9", "interval in progress keeps old length", n, 128);
    wait_trig(2000, n);
    check("R9", "next interval uses new code 2", n, 512);

    // R4: tick every third cycle
    cur_req = "R4";
    stop_cycle();
    tick_div = 3; rate_sel = 4'd0; scan_en = 1'b1;
    wait_trig(5000, n);
    wait_trig(5000, n);
    check("R4", "gap with sparse ticks", n, 384);
    stop_cycle();
    tick_div = 1;
    @(negedge clk);

    // R8: illegal code at reload, then recovery
    cur_req = "R8";
    rate_sel = 4'd0; scan_en = 1'b1;
    wait_trig(2000, n);
    rate_sel = 4'd11;
    wait_trig(2000, n);
    check("R8", "trigger still issued at illegal reload", n, 128);
    wait_trig(600, n);
    check("R8", "idle after illegal reload", n, -1);
    rate_sel = 4'd1;
    wait_trig(2000, n);
    check("R8", "restart on legal code 1", n, 257);
    stop_cycle();
    rate_sel = 4'd15; scan_en = 1'b1;
    wait_trig(600, n);
    check("R8", "code 15 never starts", n, -1);

    // R6: enable drop mid-interval
    cur_req = "R6";
    rate_sel = 4'd0;
    repeat (60) @(negedge clk);
    scan_en = 1'b0;
    wait_trig(300, n);
    check("R6", "no trigger while disabled", n, -1);
    scan_en = 1'b1;
    wait_trig(2000, n);
    check("R6", "full interval after re-enable", n, 129);

    // R7: hold-reset
    cur_req = "R7";
    repeat (40) @(negedge clk);
    hold_rst = 1'b1;
    wait_trig(400, n);
    check("R7", "no trigger under hold", n, -1);
    hold_rst = 1'b0;
    wait_trig(2000, n);
    check("R7", "full interval after hold", n, 129);

    // R2: larger codes
    cur_req = "R2";
    stop_cycle();
    rate_sel = 4'd3; scan_en = 1'b1;
    wait_trig(3000, n);
    check("R2", "start to first trigger, code 3", n, 1025);
    stop_cycle();
    rate_sel = 4'd10; scan_en = 1'b1;
    wait_trig(140000, n);
    check("R2", "start to first trigger, code 10", n, 131073);
    stop_cycle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule